// File: doc/BRIEF.md
# SDRAM Read/Write Data Path

This block is the data side of a behavioural 16-bit synchronous DRAM model. On a read it takes the word that the memory array presents in the command cycle and holds it in a short shift pipeline. The word reaches the output bus two or three clocks later, as the programmed CAS latency selects. A new read may be issued on every clock, and the words then leave the pipeline back to back with no gap.

Each byte lane has its own mask bit, and the mask acts differently on the two directions. For reads it works as an output disable that takes effect two clocks after it is sampled: a masked lane's drive enable drops and its data bits read as zero. For writes it acts at once: the per-byte write enable sent to the array is cleared in the same cycle that the mask is sampled. The write data goes straight through to the array. Command decoding and array timing sit outside this block. Its neighbours present one read strobe or one write strobe per cycle.

Top module: `sdram_dq_path`

## Requirements
- R1: While `rst_n` is low at a rising edge, every pipeline stage is cleared. After that edge `dq_oe` is 2'b00 and `dq_out` is zero.
- R2: With `cas_lat` equal to 2, a read sampled at edge k captures `arr_rdata` at that edge. The word is driven on `dq_out` with its lanes enabled from edge k+1 until edge k+2.
- R3: With `cas_lat` equal to 3, a read sampled at edge k drives its captured word from edge k+2 until edge k+3.
- R4: Reads sampled on consecutive edges appear on consecutive cycles, in issue order, with no idle cycle between them.
- R5: Lane 0 is `dq_out[7:0]` with mask bit `dqm[0]`, and lane 1 is `dq_out[15:8]` with mask bit `dqm[1]`. A mask bit high at edge m clears that lane's bit of `dq_oe` for the cycle from edge m+1 to edge m+2, whichever read is being output then.
- R6: The bits of a lane whose `dq_oe` bit is low read as zero on `dq_out`.
- R7: In the same cycle, `arr_we[i]` equals `wr_cmd & ~dqm[i]` and `arr_wdata` equals `wr_data`.
- R8: `dq_oe` is nonzero only in the output cycle of a sampled read. Writes and mask activity without a read leave `dq_oe` at zero and `dq_out` at zero.
- R9: A `cas_lat` value of 3 selects the three-cycle delay. Every other value, including 0 and 1, selects the two-cycle delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cas_lat | input | 2 | Programmed read latency (3 selects three cycles, else two) |
| rd_cmd | input | 1 | Read strobe for this cycle |
| wr_cmd | input | 1 | Write strobe for this cycle |
| dqm | input | 2 | Per-lane mask bits, bit 0 is the lower byte |
| wr_data | input | 16 | Write data sampled from the bus |
| arr_rdata | input | 16 | Word read from the array in the command cycle |
| dq_oe | output | 2 | Per-lane bus drive enable |
| dq_out | output | 16 | Data driven on the bus |
| arr_we | output | 2 | Per-lane write enable to the array |
| arr_wdata | output | 16 | Write data to the array |

## Verification
The bench builds the block with its default parameters: a 16-bit bus in two lanes and a pipeline three stages deep. This lets it test both selectable latencies and the fallback of the unused `cas_lat` codes to two cycles. Under each latency it runs single reads, unbroken read bursts, and masks raised in the read's own cycle and in the cycle after it. The second case matters only at latency 3, where it shows that the two-clock output-disable lag is independent of the read delay. Writes, with masks of every value, are interleaved with reads to show they never reach the read pipeline.

// File: rtl/sdram_dq_path_pkg.sv
// Package: shared constants and helpers for the SDRAM data path.
// Assumes byte-wide mask lanes and a minimum read latency of two clocks.
package sdram_dq_path_pkg;

    localparam int unsigned BYTE_W      = 8;
    localparam int unsigned CL_MIN      = 2;
    localparam int unsigned RD_MASK_LAT = 2;

    // Map a programmed latency to the pipeline tap that feeds the bus.
    function automatic int unsigned cl_tap(input int unsigned cl, input int unsigned cl_max);
        if (cl >= CL_MIN && cl <= cl_max)
            return cl - 1;
        return CL_MIN - 1;
    endfunction

endpackage

// File: rtl/sdram_rd_delay.sv
// Module: read data delay line.
// Captures the array word and a valid flag on each read strobe and shifts
// them down CL_MAX stages; the tap chosen by cas_lat drives the output.
// Assumes cas_lat is held steady while reads are in flight.
module sdram_rd_delay
    import sdram_dq_path_pkg::*;
#(
    parameter int unsigned DW     = 16,
    parameter int unsigned CL_MAX = 3,
    parameter int unsigned LW     = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [LW-1:0] cas_lat,
    input  logic          push,
    input  logic [DW-1:0] din,
    output logic          vld_out,
    output logic [DW-1:0] dout
);

    localparam int unsigned TW = (CL_MAX > 1) ? $clog2(CL_MAX) : 1;

    logic [CL_MAX-1:0] vld_q;
    logic [DW-1:0]     dat_q [CL_MAX];
    logic [TW-1:0]     tap;

    // Shift valid flags and words one stage per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(CL_MAX); i++) begin
                vld_q[i] <= 1'b0;
                dat_q[i] <= '0;
            end
        end else begin
            vld_q[0] <= push;
            dat_q[0] <= push ? din : '0;
            for (int i = 1; i < int'(CL_MAX); i++) begin
                vld_q[i] <= vld_q[i-1];
                dat_q[i] <= dat_q[i-1];
            end
        end
    end

    // Select the stage that matches the programmed latency.
    always_comb begin
        tap     = TW'(cl_tap(int'(cas_lat), CL_MAX));
        vld_out = vld_q[tap];
        dout    = dat_q[tap];
    end

    // R2: two-cycle latency delivers the captured word two edges later.
    a_r2_cl2_delivery: assert property (@(posedge clk) disable iff (!rst_n)
        (push && cas_lat == LW'(2)) |-> ##2 (vld_out && dout == $past(din, 2)));

    generate
        if (CL_MAX >= 3) begin : g_cl3_check
            // R3: three-cycle latency delivers the captured word three edges later.
            a_r3_cl3_delivery: assert property (@(posedge clk) disable iff (!rst_n)
                (push && cas_lat == LW'(3)) |-> ##3 (vld_out && dout == $past(din, 3)));
        end
    endgenerate

endmodule

// File: rtl/sdram_mask_pipe.sv
// Module: read-side mask delay.
// Delays the per-lane mask bits by LAT clocks so that they line up with the
// bus cycle they disable. Assumes LAT is at least one.
module sdram_mask_pipe #(
    parameter int unsigned LANES = 2,
    parameter int unsigned LAT   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] mask_in,
    output logic [LANES-1:0] mask_out
);

    logic [LANES-1:0] st [LAT];

    // Shift the mask bits through LAT stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(LAT); i++)
                st[i] <= '0;
        end else begin
            st[0] <= mask_in;
            for (int i = 1; i < int'(LAT); i++)
                st[i] <= st[i-1];
        end
    end

    // Present the oldest stage.
    always_comb mask_out = st[LAT-1];

    // R5: a raised mask bit shows at the output two edges after sampling.
    a_r5_mask_lag: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_in != '0) |-> ##2 (mask_out == $past(mask_in, 2)));

endmodule

// File: rtl/sdram_wr_gate.sv
// Module: write byte gating.
// Forms per-lane array write enables from the write strobe and the mask
// sampled in the same cycle; the data passes straight through.
module sdram_wr_gate #(
    parameter int unsigned DW    = 16,
    parameter int unsigned LANES = 2
) (
    input  logic             wr_cmd,
    input  logic [LANES-1:0] dqm,
    input  logic [DW-1:0]    wr_data,
    output logic [LANES-1:0] we,
    output logic [DW-1:0]    wdata
);

    genvar g;
    generate
        for (g = 0; g < int'(LANES); g++) begin : g_lane
            // Enable a lane only when it is written and not masked.
            assign we[g] = wr_cmd & ~dqm[g];
        end
    endgenerate

    // Forward the write word unchanged.
    assign wdata = wr_data;

endmodule

// File: rtl/sdram_dq_path.sv
// Module: SDRAM data path top.
// Joins the read delay line, the read mask delay and the write gating, and
// forms per-lane bus enables and lane-zeroed output data.
// Assumes at most one of rd_cmd and wr_cmd per cycle and a cas_lat that only
// changes while no read is in flight.
module sdram_dq_path
    import sdram_dq_path_pkg::*;
#(
    parameter int unsigned DQ_W   = 16,
    parameter int unsigned CL_MAX = 3,
    parameter int unsigned CL_W   = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [CL_W-1:0]        cas_lat,
    input  logic                   rd_cmd,
    input  logic                   wr_cmd,
    input  logic [DQ_W/BYTE_W-1:0] dqm,
    input  logic [DQ_W-1:0]        wr_data,
    input  logic [DQ_W-1:0]        arr_rdata,
    output logic [DQ_W/BYTE_W-1:0] dq_oe,
    output logic [DQ_W-1:0]        dq_out,
    output logic [DQ_W/BYTE_W-1:0] arr_we,
    output logic [DQ_W-1:0]        arr_wdata
);

    localparam int unsigned LANES = DQ_W / BYTE_W;

    logic             rd_vld;
    logic [DQ_W-1:0]  rd_word;
    logic [LANES-1:0] mask_d;

    sdram_rd_delay #(.DW(DQ_W), .CL_MAX(CL_MAX), .LW(CL_W)) u_rd_delay (
        .clk     (clk),
        .rst_n   (rst_n),
        .cas_lat (cas_lat),
        .push    (rd_cmd),
        .din     (arr_rdata),
        .vld_out (rd_vld),
        .dout    (rd_word)
    );

    sdram_mask_pipe #(.LANES(LANES), .LAT(RD_MASK_LAT)) u_mask_pipe (
        .clk      (clk),
        .rst_n    (rst_n),
        .mask_in  (dqm),
        .mask_out (mask_d)
    );

    sdram_wr_gate #(.DW(DQ_W), .LANES(LANES)) u_wr_gate (
        .wr_cmd  (wr_cmd),
        .dqm     (dqm),
        .wr_data (wr_data),
        .we      (arr_we),
        .wdata   (arr_wdata)
    );

    genvar g;
    generate
        for (g = 0; g < int'(LANES); g++) begin : g_bus_lane
            // Drive a lane when read data is due and its delayed mask is low.
            assign dq_oe[g] = rd_vld & ~mask_d[g];
            // Zero the lane's bits while it is not driven.
            assign dq_out[g*BYTE_W +: BYTE_W] = dq_oe[g] ? rd_word[g*BYTE_W +: BYTE_W] : '0;
        end
    endgenerate

    // R8: any driven lane traces back to a read sampled at the latency.
    a_r8_oe_from_read: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_oe != '0) |-> ((cas_lat == CL_W'(3)) ? $past(rd_cmd, 3) : $past(rd_cmd, 2)));

endmodule

// File: tb/sdram_dq_path_test.sv
module sdram_dq_path_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cas_lat = 2'd2;
    logic        rd_cmd = 1'b0;
    logic        wr_cmd = 1'b0;
    logic [1:0]  dqm = 2'b00;
    logic [15:0] wr_data = '0;
    logic [15:0] arr_rdata = '0;
    logic [1:0]  dq_oe;
    logic [15:0] dq_out;
    logic [1:0]  arr_we;
    logic [15:0] arr_wdata;

    always #2 clk = ~clk;

    sdram_dq_path uut (
        .clk(clk), .rst_n(rst_n), .cas_lat(cas_lat), .rd_cmd(rd_cmd),
        .wr_cmd(wr_cmd), .dqm(dqm), .wr_data(wr_data), .arr_rdata(arr_rdata),
        .dq_oe(dq_oe), .dq_out(dq_out), .arr_we(arr_we), .arr_wdata(arr_wdata)
    );

    typedef struct {
        int          due;
        logic [15:0] data;
    } item_t;

    item_t       exp_q [$];
    string       tag_q [$];
    logic [1:0]  mask_hist [0:4095];
    int          edge_n = 0;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    initial for (int i = 0; i < 4096; i++) mask_hist[i] = 2'b00;

    always @(posedge clk) edge_n++;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at edge %0d", tag, act, exp, edge_n);
        end
    endtask

    // Monitor: compares the bus against the scoreboard after each edge.
    always @(posedge clk) begin
        #1;
        if (!done) begin
            int c;
            c = edge_n;
            if (exp_q.size() > 0 && exp_q[0].due == c) begin
                item_t       it;
                string       t;
                logic [1:0]  eoe;
                logic [15:0] eout;
                it   = exp_q.pop_front();
                t    = tag_q.pop_front();
                eoe  = ~mask_hist[c-1];
                eout = {eoe[1] ? it.data[15:8] : 8'h00, eoe[0] ? it.data[7:0] : 8'h00};
                chk(dq_oe == eoe, t, {30'd0, dq_oe}, {30'd0, eoe});
                chk(dq_out == eout, {t, "/R6"}, {16'd0, dq_out}, {16'd0, eout});
            end else begin
                chk(dq_oe == 2'b00, rst_n ? "R8" : "R1", {30'd0, dq_oe}, 32'd0);
                chk(dq_out == 16'h0, rst_n ? "R8/R6" : "R1", {16'd0, dq_out}, 32'd0);
            end
        end
    end

    // Driver: applies one cycle of stimulus and records what it expects.
    task automatic step(input logic rd, input logic wr, input logic [1:0] m,
                        input logic [15:0] rdat, input logic [15:0] wdat, input string tag);
        int e;
        int cl;
        logic [1:0] ew;
        @(negedge clk);
        rd_cmd    = rd;
        wr_cmd    = wr;
        dqm       = m;
        arr_rdata = rdat;
        wr_data   = wdat;
        e = edge_n + 1;
        mask_hist[e] = m;
        if (rd) begin
            cl = (cas_lat == 2'd3) ? 3 : 2;
            exp_q.push_back('{due: e + cl - 1, data: rdat});
            tag_q.push_back(tag);
        end
        #1;
        ew = wr ? ~m : 2'b00;
        chk(arr_we == ew, "R7", {30'd0, arr_we}, {30'd0, ew});
        if (wr) chk(arr_wdata == wdat, "R7", {16'd0, arr_wdata}, {16'd0, wdat});
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, 2'b00, 16'h0, 16'h0, "R8");
    endtask

    task automatic latency_suite(input string tag);
        step(1'b1, 1'b0, 2'b00, 16'hA1B2, 16'h0, tag);
        idle(3);
        step(1'b1, 1'b0, 2'b00, 16'h3C4D, 16'h0, tag);
        idle(4);
        for (int i = 0; i < 8; i++)
            step(1'b1, 1'b0, 2'b00, 16'h1000 + 16'(i * 16'h0111), 16'h0, "R4");
        idle(4);
        step(1'b1, 1'b0, 2'b01, 16'hA5C3, 16'h0, "R5");
        step(1'b1, 1'b0, 2'b10, 16'h5A3C, 16'h0, "R5");
        step(1'b1, 1'b0, 2'b11, 16'hFFEE, 16'h0, "R5");
        step(1'b1, 1'b0, 2'b00, 16'h7788, 16'h0, "R5");
        step(1'b0, 1'b0, 2'b01, 16'h0, 16'h0, "R5");
        step(1'b1, 1'b0, 2'b00, 16'h99AA, 16'h0, "R5");
        step(1'b0, 1'b0, 2'b10, 16'h0, 16'h0, "R5");
        idle(4);
        step(1'b1, 1'b0, 2'b00, 16'h1357, 16'h0, "R8");
        step(1'b0, 1'b1, 2'b01, 16'h0, 16'hBEEF, "R7");
        step(1'b1, 1'b0, 2'b00, 16'h2468, 16'h0, "R8");
        step(1'b0, 1'b1, 2'b00, 16'h0, 16'hCAFE, "R7");
        idle(5);
    endtask

    initial begin
        idle(4);
        rst_n = 1'b1;
        idle(2);
        // R2 and R4 with the two-cycle latency.
        cas_lat = 2'd2;
        latency_suite("R2");
        // R7/R8: writes with every mask and masks without reads.
        for (int m = 0; m < 4; m++)
            step(1'b0, 1'b1, 2'(m), 16'h0, 16'h0F0F ^ 16'(m * 16'h1111), "R7");
        step(1'b0, 1'b0, 2'b11, 16'hFFFF, 16'h0, "R8");
        step(1'b0, 1'b0, 2'b01, 16'hFFFF, 16'h0, "R8");
        idle(4);
        // R3 with the three-cycle latency.
        cas_lat = 2'd3;
        latency_suite("R3");
        // R9: codes 0 and 1 fall back to two cycles.
        cas_lat = 2'd0;
        latency_suite("R9");
        cas_lat = 2'd1;
        step(1'b1, 1'b0, 2'b00, 16'hD00D, 16'h0, "R9");
        step(1'b1, 1'b0, 2'b00, 16'hE00E, 16'h0, "R9");
        idle(5);
        chk(exp_q.size() == 0, "R4", exp_q.size(), 32'd0);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule